// File: doc/BRIEF.md
# Host/Processor Shared Control Register

This block is a 16-bit control word that two agents share: an external host and a local graphics processor. Each side has its own write port with byte enables and its own read port. The low byte is a two-way mailbox. It carries a 3-bit message and an interrupt-request bit in each direction. The high byte carries system controls that either side may write: a nonmaskable interrupt request and its mode bit, a cache-flush level, a halt level, two address auto-increment enables and a byte-order select.

Every bit has its own rule for who may set it and who may clear it. The host raises the inbound request and the processor clears it. The processor raises the outbound request and the host clears it. The NMI bit clears itself when the interrupt sequencer reports that the interrupt was taken. The halt bit takes its value after reset from the host chip-select pin.

The host signals arrive asynchronously and pass through a synchronizer before they act on the register. The processor port sits in the register's own clock domain.

Top module: `host_proc_ctl_reg`

## Requirements
- R1: Word layout. Bits [2:0] hold the inbound message, bit 3 the inbound request, bits [6:4] the outbound message, bit 7 the outbound request, bit 8 NMI, bit 9 NMI mode, bit 11 write-increment, bit 12 read-increment, bit 13 byte order, bit 14 cache flush and bit 15 halt. Bit 10 is reserved: it reads 0 and ignores writes. Both read ports show the same word.
- R2: Only a host write of the low byte changes bits [2:0]. A processor write of the low byte leaves them unchanged.
- R3: A host write of 1 to bit 3 sets it, and a processor write of 0 to bit 3 clears it. A host write of 0 and a processor write of 1 have no effect. `int_pend_o` always equals bit 3.
- R4: Only a processor write of the low byte changes bits [6:4]. A host write of the low byte leaves them unchanged.
- R5: A processor write of 1 to bit 7 sets it, and a host write of 0 to bit 7 clears it. A host write of 1 and a processor write of 0 have no effect. `host_int_no` is low exactly while bit 7 is 1.
- R6: When both sides write the low byte on the same edge, both sides' permitted updates are applied on that edge. If a set and a clear of bit 3 or bit 7 meet on the same edge, the set wins.
- R7: Either side may write the high byte. When both write it on the same edge, the host's value is taken. The outputs `nmi_mode_o`, `inc_wr_o`, `inc_rd_o`, `lbl_o`, `cache_flush_o` and `halt_o` follow bits 9, 11, 12, 13, 14 and 15.
- R8: A write of 1 to bit 8 raises `nmi_req_o`. `nmi_ack_i` clears the bit on the next edge. A high-byte write on the same edge as the acknowledge takes precedence over it.
- R9: On the first rising clock edge after `rst_ni` is released, the halt bit loads the level of `hcs_i`.
- R10: A host write presented for one cycle takes effect on the (SYNC_STAGES+1)-th rising edge after it is presented. The word is unchanged before that edge.
- R11: A write changes only the bytes whose enable bit is 1 (`be[0]` selects bits [7:0], `be[1]` selects bits [15:8]).
- R12: While reset is asserted, the word reads 0x8000: halt is 1 and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock (processor domain) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hcs_i | input | 1 | Host chip-select level, sampled for the halt bit after reset |
| host_we_i | input | 1 | Host write strobe (asynchronous) |
| host_be_i | input | 2 | Host byte enables |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Word as seen by the host |
| proc_we_i | input | 1 | Processor write strobe |
| proc_be_i | input | 2 | Processor byte enables |
| proc_wdata_i | input | 16 | Processor write data |
| proc_rdata_o | output | 16 | Word as seen by the processor |
| nmi_ack_i | input | 1 | NMI taken acknowledge |
| host_int_no | output | 1 | Active-low interrupt to host |
| int_pend_o | output | 1 | Host-to-processor interrupt pending |
| nmi_req_o | output | 1 | Nonmaskable interrupt request |
| nmi_mode_o | output | 1 | NMI context mode |
| halt_o | output | 1 | Halt processor level |
| cache_flush_o | output | 1 | Flush/disable cache level |
| inc_wr_o | output | 1 | Increment address after write |
| inc_rd_o | output | 1 | Increment address before read |
| lbl_o | output | 1 | Lower-byte-last order select |

## Verification
The bench builds the block with SYNC_STAGES = 3, one stage more than the default. At that depth the host-path latency is measured against the parameter rather than against a fixed number: the bench samples one cycle before the write lands and on the cycle it lands. The bench also times a processor write to reach the register on the same edge as a synchronized host write. It does this for both bytes, which exercises the set-beats-clear and host-wins rules, and it repeats this with an NMI acknowledge in the same cycle as a write.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int unsigned MSG_W  = 3;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam int unsigned LANES  = WORD_W / BYTE_W;

  typedef struct packed {
    logic             int_out;
    logic [MSG_W-1:0] msg_out;
    logic             int_in;
    logic [MSG_W-1:0] msg_in;
  } hpc_low_t;

  typedef struct packed {
    logic halt;
    logic cflush;
    logic lbl;
    logic inc_rd;
    logic inc_wr;
    logic rsvd;
    logic nmi_mode;
    logic nmi;
  } hpc_high_t;
endpackage

// File: rtl/hpc_sync.sv
module hpc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/hpc_low_ctl.sv
module hpc_low_ctl
  import hpc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              h_wr_i,
  input  logic [BYTE_W-1:0] h_wdata_i,
  input  logic              p_wr_i,
  input  logic [BYTE_W-1:0] p_wdata_i,
  output hpc_low_t          low_o
);
  hpc_low_t q, n, hw, pw;

  assign hw = hpc_low_t'(h_wdata_i);
  assign pw = hpc_low_t'(p_wdata_i);

  // clears first, sets last: a set meeting a clear wins
  always_comb begin
    n = q;
    if (h_wr_i) n.msg_in  = hw.msg_in;
    if (p_wr_i) n.msg_out = pw.msg_out;
    if (p_wr_i && !pw.int_in)  n.int_in  = 1'b0;
    if (h_wr_i &&  hw.int_in)  n.int_in  = 1'b1;
    if (h_wr_i && !hw.int_out) n.int_out = 1'b0;
    if (p_wr_i &&  pw.int_out) n.int_out = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= n;
  end

  assign low_o = q;
endmodule

// File: rtl/hpc_high_ctl.sv
module hpc_high_ctl
  import hpc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hcs_i,
  input  logic              h_wr_i,
  input  logic [BYTE_W-1:0] h_wdata_i,
  input  logic              p_wr_i,
  input  logic [BYTE_W-1:0] p_wdata_i,
  input  logic              nmi_ack_i,
  output hpc_high_t         high_o,
  output logic              init_o
);
  hpc_high_t q, n, wd;
  logic      init_q;

  assign wd = hpc_high_t'(h_wr_i ? h_wdata_i : p_wdata_i);

  always_comb begin
    n = q;
    if (nmi_ack_i) n.nmi = 1'b0;
    if (h_wr_i || p_wr_i) begin
      n      = wd;
      n.rsvd = 1'b0;
    end
    if (init_q) n.halt = hcs_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q      <= '0;
      q.halt <= 1'b1;
      init_q <= 1'b1;
    end else begin
      q      <= n;
      init_q <= 1'b0;
    end
  end

  assign high_o = q;
  assign init_o = init_q;
endmodule

// File: rtl/host_proc_ctl_reg.sv
module host_proc_ctl_reg
  import hpc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hcs_i,
  input  logic              host_we_i,
  input  logic [LANES-1:0]  host_be_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  input  logic              proc_we_i,
  input  logic [LANES-1:0]  proc_be_i,
  input  logic [WORD_W-1:0] proc_wdata_i,
  output logic [WORD_W-1:0] proc_rdata_o,
  input  logic              nmi_ack_i,
  output logic              host_int_no,
  output logic              int_pend_o,
  output logic              nmi_req_o,
  output logic              nmi_mode_o,
  output logic              halt_o,
  output logic              cache_flush_o,
  output logic              inc_wr_o,
  output logic              inc_rd_o,
  output logic              lbl_o
);
  localparam int unsigned SYNC_W = 1 + LANES + WORD_W;

  logic              hs_we;
  logic [LANES-1:0]  hs_be;
  logic [WORD_W-1:0] hs_wdata;
  logic [LANES-1:0]  hs_lane, p_lane;
  hpc_low_t          low;
  hpc_high_t         high;
  logic              init;
  logic [WORD_W-1:0] word;

  hpc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({host_we_i, host_be_i, host_wdata_i}),
    .q_o   ({hs_we, hs_be, hs_wdata})
  );

  for (genvar b = 0; b < int'(LANES); b++) begin : g_lane
    assign hs_lane[b] = hs_we & hs_be[b];
    assign p_lane[b]  = proc_we_i & proc_be_i[b];
  end

  hpc_low_ctl u_low (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .h_wr_i   (hs_lane[0]),
    .h_wdata_i(hs_wdata[BYTE_W-1:0]),
    .p_wr_i   (p_lane[0]),
    .p_wdata_i(proc_wdata_i[BYTE_W-1:0]),
    .low_o    (low)
  );

  hpc_high_ctl u_high (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hcs_i    (hcs_i),
    .h_wr_i   (hs_lane[1]),
    .h_wdata_i(hs_wdata[WORD_W-1:BYTE_W]),
    .p_wr_i   (p_lane[1]),
    .p_wdata_i(proc_wdata_i[WORD_W-1:BYTE_W]),
    .nmi_ack_i(nmi_ack_i),
    .high_o   (high),
    .init_o   (init)
  );

  assign word          = {high, low};
  assign host_rdata_o  = word;
  assign proc_rdata_o  = word;
  assign host_int_no   = ~low.int_out;
  assign int_pend_o    = low.int_in;
  assign nmi_req_o     = high.nmi;
  assign nmi_mode_o    = high.nmi_mode;
  assign halt_o        = high.halt;
  assign cache_flush_o = high.cflush;
  assign inc_wr_o      = high.inc_wr;
  assign inc_rd_o      = high.inc_rd;
  assign lbl_o         = high.lbl;
endmodule

// File: rtl/hpc_checker.sv
module hpc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        hcs_i,
  input logic        init,
  input logic [1:0]  hs_lane,
  input logic [15:0] hs_wdata,
  input logic [1:0]  p_lane,
  input logic [15:0] proc_wdata_i,
  input logic        nmi_ack_i,
  input logic [15:0] host_rdata_o,
  input logic [15:0] proc_rdata_o,
  input logic        host_int_no,
  input logic        int_pend_o,
  input logic        nmi_req_o,
  input logic        halt_o
);
  assert_msg_in_owner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_lane[0] |=> $stable(host_rdata_o[2:0]));

  assert_int_in_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_pend_o) |-> $past(hs_lane[0] && hs_wdata[3]));

  assert_int_in_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_pend_o) |-> $past(p_lane[0] && !proc_wdata_i[3]));

  assert_msg_out_owner_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_lane[0] |=> $stable(proc_rdata_o[6:4]));

  assert_int_out_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_int_no) |-> $past(p_lane[0] && proc_wdata_i[7]));

  assert_int_out_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_int_no) |-> $past(hs_lane[0] && !hs_wdata[7]));

  assert_host_wins_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_lane[1] && !init) |=> (halt_o == $past(hs_wdata[15])));

  assert_nmi_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_req_o && nmi_ack_i && !hs_lane[1] && !p_lane[1]) |=> !nmi_req_o);

  assert_halt_init_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init |=> (halt_o == $past(hcs_i)));
endmodule

bind host_proc_ctl_reg hpc_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hcs_i       (hcs_i),
  .init        (init),
  .hs_lane     (hs_lane),
  .hs_wdata    (hs_wdata),
  .p_lane      (p_lane),
  .proc_wdata_i(proc_wdata_i),
  .nmi_ack_i   (nmi_ack_i),
  .host_rdata_o(host_rdata_o),
  .proc_rdata_o(proc_rdata_o),
  .host_int_no (host_int_no),
  .int_pend_o  (int_pend_o),
  .nmi_req_o   (nmi_req_o),
  .halt_o      (halt_o)
);

// File: tb/tb_host_proc_ctl_reg.sv
module tb_host_proc_ctl_reg;
  localparam int SYNC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hcs = 1'b1;
  logic host_we = 1'b0, proc_we = 1'b0, nmi_ack = 1'b0;
  logic [1:0]  host_be = '0, proc_be = '0;
  logic [15:0] host_wdata = '0, proc_wdata = '0;
  logic [15:0] host_rdata, proc_rdata;
  logic host_int_n, int_pend, nmi_req, nmi_mode, halt, cflush, inc_wr, inc_rd, lbl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  host_proc_ctl_reg #(.SYNC_STAGES(SYNC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hcs_i(hcs),
    .host_we_i(host_we), .host_be_i(host_be), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata),
    .proc_we_i(proc_we), .proc_be_i(proc_be), .proc_wdata_i(proc_wdata),
    .proc_rdata_o(proc_rdata),
    .nmi_ack_i(nmi_ack), .host_int_no(host_int_n), .int_pend_o(int_pend),
    .nmi_req_o(nmi_req), .nmi_mode_o(nmi_mode), .halt_o(halt),
    .cache_flush_o(cflush), .inc_wr_o(inc_wr), .inc_rd_o(inc_rd), .lbl_o(lbl)
  );

  typedef struct {
    string       req;
    logic [15:0] exp;
  } item_t;
  item_t sb_q[$];

  task automatic expect_word(input string req, input logic [15:0] e);
    item_t it;
    it.req = req;
    it.exp = e;
    sb_q.push_back(it);
  endtask

  // monitor: compares every output against the expected word
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [42:0] obs, exp;
        it  = sb_q.pop_front();
        obs = {host_rdata, proc_rdata, host_int_n, int_pend, nmi_req, nmi_mode,
               inc_wr, inc_rd, lbl, cflush, halt};
        exp = {it.exp, it.exp, ~it.exp[7], it.exp[3], it.exp[8], it.exp[9],
               it.exp[11], it.exp[12], it.exp[13], it.exp[14], it.exp[15]};
        checks++;
        if (obs !== exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.req, obs, exp);
        end
      end
    end
  end

  task automatic host_wr(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_be = be; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    repeat (SYNC) @(negedge clk);
  endtask

  task automatic proc_wr(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    proc_we = 1'b1; proc_be = be; proc_wdata = d;
    @(negedge clk);
    proc_we = 1'b0;
  endtask

  // host and processor writes reach the register on the same edge
  task automatic both_wr(input logic [1:0] be, input logic [15:0] hd, input logic [15:0] pd);
    @(negedge clk);
    host_we = 1'b1; host_be = be; host_wdata = hd;
    @(negedge clk);
    host_we = 1'b0;
    repeat (SYNC - 1) @(negedge clk);
    proc_we = 1'b1; proc_be = be; proc_wdata = pd;
    @(negedge clk);
    proc_we = 1'b0;
  endtask

  task automatic do_reset(input logic h);
    @(negedge clk);
    rst_n = 1'b0;
    hcs   = h;
    @(negedge clk);
    expect_word("R12 reset value", 16'h8000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    expect_word("R9 halt from hcs high", 16'h8000);

    // R10 latency: unchanged one cycle before the landing edge
    @(negedge clk);
    host_we = 1'b1; host_be = 2'b01; host_wdata = 16'h000F;
    @(negedge clk);
    host_we = 1'b0;
    repeat (SYNC - 1) @(negedge clk);
    expect_word("R10 before landing", 16'h8000);
    @(negedge clk);
    expect_word("R10 R2 R3 host sets msg_in and int_in", 16'h800F);

    proc_wr(2'b01, 16'h0000);
    expect_word("R2 R3 proc clears int_in, msg_in kept", 16'h8007);
    proc_wr(2'b01, 16'h00F8);
    expect_word("R4 R5 proc sets msg_out/int_out, R3 proc 1 ignored", 16'h80F7);
    host_wr(2'b01, 16'h0000);
    expect_word("R5 host clears int_out, R3 host 0 ignored, R4", 16'h8070);
    host_wr(2'b01, 16'h0088);
    expect_word("R5 host 1 ignored, R3 host sets", 16'h8078);
    proc_wr(2'b01, 16'h0008);
    expect_word("R3 proc 1 ignored, R4 msg_out write", 16'h8008);

    both_wr(2'b01, 16'h0005, 16'h00A0);
    expect_word("R6 both low updates applied", 16'h80A5);
    both_wr(2'b01, 16'h0008, 16'h0080);
    expect_word("R6 set beats clear", 16'h8088);

    proc_wr(2'b10, 16'h0000);
    expect_word("R7 proc clears halt", 16'h0088);
    host_wr(2'b10, 16'h7B00);
    expect_word("R7 R8 host writes high byte", 16'h7B88);
    @(negedge clk);
    nmi_ack = 1'b1;
    @(negedge clk);
    nmi_ack = 1'b0;
    expect_word("R8 ack clears nmi", 16'h7A88);
    host_wr(2'b10, 16'h0400);
    expect_word("R1 reserved bit reads zero", 16'h0088);

    proc_wr(2'b10, 16'h80FF);
    expect_word("R11 high-only write keeps low", 16'h8088);
    host_wr(2'b01, 16'hFF00);
    expect_word("R11 low-only write keeps high", 16'h8008);

    both_wr(2'b10, 16'h4000, 16'h8000);
    expect_word("R7 host wins high byte", 16'h4008);

    @(negedge clk);
    proc_we = 1'b1; proc_be = 2'b10; proc_wdata = 16'h0100; nmi_ack = 1'b1;
    @(negedge clk);
    proc_we = 1'b0; nmi_ack = 1'b0;
    expect_word("R8 write beats ack", 16'h0108);

    do_reset(1'b0);
    expect_word("R9 R12 halt from hcs low", 16'h0000);

    @(negedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule